// File: doc/BRIEF.md
# GPIO port with per-pin interrupt detection

This block is a 32-pin general-purpose I/O port on a simple memory-mapped register bus. Software writes an output value and a per-pin direction, reads the synchronised pad levels back, and sets up each pin to raise an interrupt. The pin can trigger on a low level, a high level, a rising edge or a falling edge. A separate per-pin bit selects detection on both edges.

Each pad input passes through a two-flop synchroniser before any detection runs. Every detected event sets a sticky status bit, and software clears that bit by writing a one to it. A status bit combines with its mask bit to drive one of two interrupt lines. Pins 0 to 15 feed the lower line and pins 16 to 31 feed the upper line. A bus read returns data one clock after the address is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output data, direction, both trigger-configuration, mask and edge-select registers read zero, and pad_oe, pad_out, irq_lo and irq_hi are all low.
- R2: A write to the output-data register (offset 0x00) appears on pad_out, and a write to the direction register (offset 0x04) appears on pad_oe, from the clock edge that performs the write. pad_oe changes only on such a write.
- R3: The pad-status register (offset 0x08, read only) returns pad_in after two synchronising flops. A read whose address is presented in the same cycle as the pad change, or in the cycle after it, returns the old value. A read presented two cycles after the change returns the new value.
- R4: Each pin has a 2-bit trigger code at bits 2*(p mod 16)+1 : 2*(p mod 16). Pins 0-15 use the low configuration word (offset 0x0C) and pins 16-31 use the high configuration word (offset 0x10). The code values are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge.
- R5: An edge-coded pin sets its status bit (offset 0x18, bit p) once on each edge of the selected polarity. An edge of the other polarity has no effect.
- R6: A level-coded pin sets its status bit on every cycle that its level is present. A clear is therefore undone while the level lasts, and it takes effect once the level has gone. Because the reset code is low level, pins held low after reset show status set.
- R7: When edge-select bit p (offset 0x1C) is 1, pin p sets status on both rising and falling edges, and its trigger code is ignored.
- R8: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it unchanged.
- R9: When a detection event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: irq_lo is high one cycle after any pin 0-15 has both its status bit and its mask bit (offset 0x14) at 1. irq_hi does the same for pins 16-31. With the mask bits at 0 both lines stay low.
- R11: Every register that is written reads back its stored value at its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the address |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output values |
| pad_oe | output | 32 | Output enables, 1 = drive |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
The hardest case to reach from the ports is an edge detection and a clearing write landing on the same status bit in the same cycle. The stimulus gets there by counting the pipeline. The pad is changed at a falling clock edge. The clearing write is then issued two falling edges later, so that it completes at the same rising edge at which the synchroniser output and the previous-value register produce the event. A second clear with no coincident event follows, to show that clearing still works. Level-triggered pins are tested by clearing while the level is held, and again after it drops. This separates the re-set-every-cycle rule from ordinary write-one-to-clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register word index = byte address bits [4:2]
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_EDGE   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int unsigned REG_IDX_W = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] level,
  input  logic [PINS-1:0] cfg_lo,
  input  logic [PINS-1:0] cfg_hi,
  input  logic [PINS-1:0] both_edges,
  output logic [PINS-1:0] hit
);

  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0] level_prev_q;

  always_ff @(posedge clk) begin
    if (rst) level_prev_q <= '0;
    else     level_prev_q <= level;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    trig_e code;
    logic  rise, fall;

    if (p < HALF) begin : g_low_word
      assign code = trig_e'(cfg_lo[2*p +: 2]);
    end else begin : g_high_word
      assign code = trig_e'(cfg_hi[2*(p-HALF) +: 2]);
    end

    assign rise =  level[p] & ~level_prev_q[p];
    assign fall = ~level[p] &  level_prev_q[p];

    always_comb begin
      if (both_edges[p]) begin
        hit[p] = rise | fall;
      end else begin
        unique case (code)
          TRIG_LOW:  hit[p] = ~level[p];
          TRIG_HIGH: hit[p] =  level[p];
          TRIG_RISE: hit[p] = rise;
          TRIG_FALL: hit[p] = fall;
          default:   hit[p] = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_level,
  input  logic [PINS-1:0]   hit,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   cfg_lo_q,
  output logic [PINS-1:0]   cfg_hi_q,
  output logic [PINS-1:0]   mask_q,
  output logic [PINS-1:0]   edge_q,
  output logic [PINS-1:0]   stat_q
);

  reg_idx_e        idx;
  logic [PINS-1:0] clr_vec;
  logic            unused_addr_lsb;

  assign idx             = reg_idx_e'(bus_addr[ADDR_W-1:2]);
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign clr_vec         = (bus_we && idx == REG_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
    end else if (bus_we) begin
      unique case (idx)
        REG_DATA:   data_q   <= bus_wdata;
        REG_DIR:    dir_q    <= bus_wdata;
        REG_CFG_LO: cfg_lo_q <= bus_wdata;
        REG_CFG_HI: cfg_hi_q <= bus_wdata;
        REG_MASK:   mask_q   <= bus_wdata;
        REG_EDGE:   edge_q   <= bus_wdata;
        default:    ;
      endcase
    end
  end

  // Sticky status: a set event overrides a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_vec) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (idx)
        REG_DATA:   bus_rdata <= data_q;
        REG_DIR:    bus_rdata <= dir_q;
        REG_PAD:    bus_rdata <= pad_level;
        REG_CFG_LO: bus_rdata <= cfg_lo_q;
        REG_CFG_HI: bus_rdata <= cfg_hi_q;
        REG_MASK:   bus_rdata <= mask_q;
        REG_STAT:   bus_rdata <= stat_q;
        REG_EDGE:   bus_rdata <= edge_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0] pad_level;
  logic [PINS-1:0] hit_vec;
  logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, edge_q, stat_q;
  logic [1:0]      irq_q;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pad_in),
    .d_out (pad_level)
  );

  gpio_detect #(.PINS(PINS)) i_detect (
    .clk        (clk),
    .rst        (rst),
    .level      (pad_level),
    .cfg_lo     (cfg_lo_q),
    .cfg_hi     (cfg_hi_q),
    .both_edges (edge_q),
    .hit        (hit_vec)
  );

  gpio_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_level (pad_level),
    .hit       (hit_vec),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .cfg_lo_q  (cfg_lo_q),
    .cfg_hi_q  (cfg_hi_q),
    .mask_q    (mask_q),
    .edge_q    (edge_q),
    .stat_q    (stat_q)
  );

  for (genvar h = 0; h < 2; h++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq_q[h] <= 1'b0;
      else     irq_q[h] <= |(stat_q[h*HALF +: HALF] & mask_q[h*HALF +: HALF]);
    end
  end

  assign irq_lo  = irq_q[0];
  assign irq_hi  = irq_q[1];
  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   pad_oe,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [PINS-1:0]   stat_q,
  input logic [PINS-1:0]   mask_q,
  input logic [PINS-1:0]   hit_vec
);

  localparam int unsigned HALF = PINS / 2;

  logic            past_ok;
  logic            dir_wr;
  logic [PINS-1:0] clr_w;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign dir_wr = bus_we && (bus_addr[ADDR_W-1:2] == REG_DIR);
  assign clr_w  = (bus_we && bus_addr[ADDR_W-1:2] == REG_STAT) ? bus_wdata : '0;

  assert_oe_by_write_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$stable(pad_oe) |-> $past(dir_wr));

  assert_rise_by_event_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (stat_q & ~$past(stat_q) & ~$past(hit_vec)) == '0);

  assert_fall_by_clear_R8: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ($past(stat_q) & ~stat_q & ~$past(clr_w)) == '0);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (stat_q & $past(hit_vec)) == $past(hit_vec));

  assert_irq_lo_masked_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    irq_lo |-> $past(mask_q[HALF-1:0] != '0));

  assert_irq_hi_masked_R10: assert property (@(posedge clk) disable iff (rst || !past_ok)
    irq_hi |-> $past(mask_q[PINS-1:HALF] != '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .hit_vec   (hit_vec)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;

  localparam int  PINS   = 32;
  localparam int  ADDR_W = 5;
  localparam time CLK_P  = 20ns;

  localparam logic [2:0] A_DATA = 3'd0, A_DIR = 3'd1, A_PAD = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_MASK = 3'd5, A_STAT = 3'd6, A_EDGE = 3'd7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [PINS-1:0]   bus_wdata = '0;
  logic [PINS-1:0]   bus_rdata;
  logic [PINS-1:0]   pad_in = '0;
  logic [PINS-1:0]   pad_out, pad_oe;
  logic              irq_lo, irq_hi;

  int n_vec  = 0;
  int n_fail = 0;
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;
  logic done = 1'b0;
  logic [PINS-1:0] exp_q[$];
  string           tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port #(.PINS(PINS), .ADDR_W(ADDR_W)) i_gpio_irq_port (
    .clk, .rst, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .irq_lo, .irq_hi
  );

  // Monitor: compares each read result in the cycle it appears
  always @(posedge clk) rd_seen <= rd_req;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [PINS-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [PINS-1:0] val);
    bus_addr  = {idx, 2'b00};
    bus_wdata = val;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, input logic [PINS-1:0] e, input string t);
    bus_addr = {idx, 2'b00};
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk(input logic [PINS-1:0] act, input logic [PINS-1:0] e, input string t);
    n_vec++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(pad_oe, '0, "R1 pad_oe");
    chk(pad_out, '0, "R1 pad_out");
    chk({31'd0, irq_lo}, '0, "R1 irq_lo");
    chk({31'd0, irq_hi}, '0, "R1 irq_hi");
    rd(A_DATA, '0, "R1 data");
    rd(A_DIR,  '0, "R1 dir");
    rd(A_CLO,  '0, "R1 cfg_lo");
    rd(A_CHI,  '0, "R1 cfg_hi");
    rd(A_MASK, '0, "R1 mask");
    rd(A_EDGE, '0, "R1 edge");
    rd(A_STAT, 32'hFFFF_FFFF, "R6 default low level with pads low");

    // R2 / R11 data and direction
    wr(A_DATA, 32'hA5A5_0F0F);
    wr(A_DIR,  32'hFFFF_0000);
    chk(pad_out, 32'hA5A5_0F0F, "R2 pad_out");
    chk(pad_oe,  32'hFFFF_0000, "R2 pad_oe");
    rd(A_DATA, 32'hA5A5_0F0F, "R11 data readback");
    rd(A_DIR,  32'hFFFF_0000, "R11 dir readback");

    // R4: all pins rising edge
    wr(A_CLO, 32'hAAAA_AAAA);
    wr(A_CHI, 32'hAAAA_AAAA);
    rd(A_CLO, 32'hAAAA_AAAA, "R11 cfg_lo readback");
    rd(A_CHI, 32'hAAAA_AAAA, "R11 cfg_hi readback");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, '0, "R8 clear all");

    // R3 synchroniser latency
    pad_in = 32'h1234_5678;
    rd(A_PAD, '0, "R3 same cycle old");
    rd(A_PAD, '0, "R3 next cycle old");
    rd(A_PAD, 32'h1234_5678, "R3 two cycles new");
    idle(3);
    rd(A_STAT, 32'h1234_5678, "R5 rising edges");
    wr(A_STAT, 32'h0000_5678);
    rd(A_STAT, 32'h1234_0000, "R8 write one clears, zero keeps");
    pad_in = '0;
    idle(4);
    rd(A_STAT, 32'h1234_0000, "R5 falling ignored under rising code");
    wr(A_STAT, 32'hFFFF_FFFF);

    // R4 falling code on pin 5
    wr(A_CLO, 32'hAAAA_AEAA);
    pad_in[5] = 1'b1;
    idle(4);
    rd(A_STAT, '0, "R4 falling code ignores rise");
    pad_in[5] = 1'b0;
    idle(4);
    rd(A_STAT, 32'h0000_0020, "R5 falling edge pin5");
    wr(A_STAT, 32'hFFFF_FFFF);

    // R10 interrupt lines
    pad_in[20] = 1'b1;
    idle(6);
    chk({31'd0, irq_hi}, '0, "R10 irq_hi masked");
    wr(A_MASK, 32'h0010_0000);
    idle(3);
    chk({31'd0, irq_hi}, 32'd1, "R10 irq_hi unmasked");
    chk({31'd0, irq_lo}, '0, "R10 irq_lo stays low");
    wr(A_MASK, 32'h0010_0008);
    pad_in[3] = 1'b1;
    idle(6);
    chk({31'd0, irq_lo}, 32'd1, "R10 irq_lo pin3");
    wr(A_STAT, 32'hFFFF_FFFF);
    idle(3);
    chk({31'd0, irq_lo}, '0, "R10 irq_lo after clear");
    chk({31'd0, irq_hi}, '0, "R10 irq_hi after clear");

    // R6 high level on pin 17
    wr(A_CHI, 32'hAAAA_AAA6);
    pad_in[17] = 1'b1;
    idle(4);
    rd(A_STAT, 32'h0002_0000, "R6 high level set");
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, 32'h0002_0000, "R6 clear undone while level held");
    pad_in[17] = 1'b0;
    idle(4);
    wr(A_STAT, 32'h0002_0000);
    rd(A_STAT, '0, "R6 clear after level gone");

    // R7 edge select on pin 8, R6 low level on pin 0
    wr(A_EDGE, 32'h0000_0100);
    rd(A_EDGE, 32'h0000_0100, "R11 edge readback");
    wr(A_CLO, 32'hAAA8_AEA8);
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0000_0001, "R7 code ignored pin8, R6 low level pin0");
    pad_in[0] = 1'b1;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, '0, "R6 low level gone");
    pad_in[8] = 1'b1;
    idle(4);
    rd(A_STAT, 32'h0000_0100, "R7 both edges rise");
    wr(A_STAT, 32'hFFFF_FFFF);
    pad_in[8] = 1'b0;
    idle(4);
    rd(A_STAT, 32'h0000_0100, "R7 both edges fall");
    wr(A_STAT, 32'hFFFF_FFFF);

    // R9 set wins against same-cycle clear
    pad_in[20] = 1'b0;
    idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, '0, "R9 precondition clear");
    pad_in[20] = 1'b1;
    idle(2);
    wr(A_STAT, 32'h0010_0000);
    rd(A_STAT, 32'h0010_0000, "R9 set wins over clear");
    wr(A_STAT, 32'h0010_0000);
    rd(A_STAT, '0, "R8 clear without collision");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule